// File: doc/BRIEF.md
# Global-History Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of 2-bit saturating counters and a global history register. The history register records the outcomes of the most recently resolved conditional branches. To build a table index, the block XORs a slice of the branch PC with that history. As a result, one static branch can hold a different prediction for each recent-outcome pattern it meets. The table has no tags. Two branches that map to the same entry simply share its counter.

The lookup side is purely combinational. The fetch logic presents a PC and gets back two things in the same cycle: the predicted direction and the table index that was used. The pipeline carries that index along with the branch. When the branch resolves, the pipeline returns the index together with the actual outcome on the update side. On that clock edge the addressed counter is trained and the outcome is shifted into the history. The returned index is used as given and is never recomputed from the history, which has already moved on by then.

Top module: `gshare_predictor`

## Requirements
- R1: While `rst_ni` is low, and immediately after it falls, every counter reads as weak not-taken (value 1) and the history is all zeros. A lookup then predicts not-taken and returns `lkp_idx_o` equal to `lkp_pc_i[PC_LSB +: IDX_W]`.
- R2: `lkp_taken_o` is 1 exactly when the counter at `lkp_idx_o` holds 2 or 3. Counter encoding: 0 strong not-taken, 1 weak not-taken, 2 weak taken, 3 strong taken.
- R3: An accepted update with `upd_taken_i`=1 raises the counter at `upd_idx_i` by one, stopping at 3.
- R4: An accepted update with `upd_taken_i`=0 lowers the counter at `upd_idx_i` by one, stopping at 0. From strong taken, two not-taken updates are needed before the prediction flips.
- R5: `lkp_idx_o` equals `lkp_pc_i[PC_LSB +: IDX_W]` XOR the history, with the history zero-extended into the low bits. An accepted update shifts the history left by one and puts the outcome in bit 0 (1 = taken). Only the last HIST_W outcomes are kept.
- R6: An update changes only the counter addressed by `upd_idx_i`, whatever PC is being looked up at the same time.
- R7: When `upd_valid_i` is 0, `upd_idx_i` and `upd_taken_i` have no effect. All counters and the history stay unchanged.
- R8: The counter change and the history shift for one update both take effect at the same clock edge. A lookup made in the cycle of the update still sees the values from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_pc_i | input | PC_W | PC of the branch being predicted |
| lkp_taken_o | output | 1 | Predicted direction, 1 = taken |
| lkp_idx_o | output | IDX_W | Table index used for this prediction |
| upd_valid_i | input | 1 | A resolved conditional branch is presented this cycle |
| upd_idx_i | input | IDX_W | Index recorded when the branch was predicted |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |

## Verification
A wrong counter is only visible through lookups that land on its entry. The bench therefore aims a lookup PC at every entry after every clock, computing each PC as the entry number XOR the expected history. A counter that is off by one across the taken threshold shows up in the very next sweep. A history bit that is wrong shows up at once as a mismatch between `lkp_idx_o` and the expected index, on all entries. A saturation fault stays hidden until the next outcome in the opposite direction. Because of this, the directed sequences push one counter past both ends before reversing it.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'd0,
    CTR_WEAK_NT   = 2'd1,
    CTR_WEAK_T    = 2'd2,
    CTR_STRONG_T  = 2'd3
  } ctr_e;

  localparam logic [1:0] CTR_RESET = CTR_WEAK_NT;

  function automatic logic ctr_is_taken(logic [1:0] ctr);
    return ctr[1];
  endfunction

  function automatic logic [1:0] ctr_train(logic [1:0] ctr, logic taken);
    logic [1:0] nxt;
    if (taken) nxt = (ctr == CTR_STRONG_T)  ? ctr : ctr + 2'd1;
    else       nxt = (ctr == CTR_STRONG_NT) ? ctr : ctr - 2'd1;
    return nxt;
  endfunction

endpackage

// File: rtl/gshare_ghr.sv
module gshare_ghr #(
  parameter int unsigned HIST_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              taken_i,
  output logic [HIST_W-1:0] hist_o
);

  logic [HIST_W-1:0] hist_q, hist_d;

  generate
    if (HIST_W == 1) begin : g_one
      assign hist_d = taken_i;
    end else begin : g_many
      assign hist_d = {hist_q[HIST_W-2:0], taken_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= hist_d;
  end

  assign hist_o = hist_q;

endmodule

// File: rtl/gshare_index.sv
module gshare_index #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned HIST_W = 8
) (
  input  logic [IDX_W-1:0]  pc_bits_i,
  input  logic [HIST_W-1:0] hist_i,
  output logic [IDX_W-1:0]  idx_o
);

  logic [IDX_W-1:0] hist_ext;

  generate
    if (HIST_W > IDX_W) begin : g_bad
      $error("history longer than index");
    end else if (HIST_W == IDX_W) begin : g_full
      assign hist_ext = hist_i;
    end else begin : g_part
      assign hist_ext = {{(IDX_W-HIST_W){1'b0}}, hist_i};
    end
  endgenerate

  assign idx_o = pc_bits_i ^ hist_ext;

endmodule

// File: rtl/gshare_ctr_table.sv
module gshare_ctr_table
  import gshare_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [IDX_W-1:0]      rd_idx_i,
  output logic [1:0]            rd_ctr_o,
  input  logic                  wr_en_i,
  input  logic [IDX_W-1:0]      wr_idx_i,
  input  logic                  wr_taken_i,
  output logic [DEPTH-1:0][1:0] ctr_o
);

  logic [DEPTH-1:0][1:0] ctr_q;
  logic [1:0]            wr_next;

  // one shared trainer feeds whichever entry is addressed
  assign wr_next = ctr_train(ctr_q[wr_idx_i], wr_taken_i);

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        ctr_q[e] <= CTR_RESET;
      else if (wr_en_i && (wr_idx_i == IDX_W'(e)))
        ctr_q[e] <= wr_next;
    end
  end

  assign rd_ctr_o = ctr_q[rd_idx_i];
  assign ctr_o    = ctr_q;

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned HIST_W = 8,
  parameter int unsigned PC_LSB = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PC_W-1:0]  lkp_pc_i,
  output logic             lkp_taken_o,
  output logic [IDX_W-1:0] lkp_idx_o,
  input  logic             upd_valid_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_taken_i
);

  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0]     hist_q;
  logic [IDX_W-1:0]      pc_bits;
  logic [1:0]            lkp_ctr;
  logic [DEPTH-1:0][1:0] ctr_q;

  assign pc_bits = lkp_pc_i[PC_LSB +: IDX_W];

  gshare_ghr #(.HIST_W(HIST_W)) i_ghr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(upd_valid_i),
    .taken_i(upd_taken_i),
    .hist_o (hist_q)
  );

  gshare_index #(.IDX_W(IDX_W), .HIST_W(HIST_W)) i_index (
    .pc_bits_i(pc_bits),
    .hist_i   (hist_q),
    .idx_o    (lkp_idx_o)
  );

  gshare_ctr_table #(.IDX_W(IDX_W)) i_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (lkp_idx_o),
    .rd_ctr_o  (lkp_ctr),
    .wr_en_i   (upd_valid_i),
    .wr_idx_i  (upd_idx_i),
    .wr_taken_i(upd_taken_i),
    .ctr_o     (ctr_q)
  );

  assign lkp_taken_o = ctr_is_taken(lkp_ctr);

endmodule

// File: rtl/gshare_checker.sv
module gshare_checker #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned HIST_W = 8,
  localparam int unsigned DEPTH = 1 << IDX_W
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  upd_valid_i,
  input logic [IDX_W-1:0]      upd_idx_i,
  input logic                  upd_taken_i,
  input logic [IDX_W-1:0]      lkp_idx_o,
  input logic                  lkp_taken_o,
  input logic [HIST_W-1:0]     hist_q,
  input logic [DEPTH-1:0][1:0] ctr_q
);

  assert_pred_threshold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_taken_o == (ctr_q[lkp_idx_o] >= 2'd2));

  assert_count_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i) |=>
      (($past(ctr_q[upd_idx_i]) == 2'd3) ? (ctr_q[$past(upd_idx_i)] == 2'd3)
        : (ctr_q[$past(upd_idx_i)] == $past(ctr_q[upd_idx_i]) + 2'd1)));

  assert_count_down_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i) |=>
      (($past(ctr_q[upd_idx_i]) == 2'd0) ? (ctr_q[$past(upd_idx_i)] == 2'd0)
        : (ctr_q[$past(upd_idx_i)] == $past(ctr_q[upd_idx_i]) - 2'd1)));

  assert_hist_shift_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> hist_q == HIST_W'({$past(hist_q), $past(upd_taken_i)}));

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> ($stable(hist_q) && $stable(ctr_q)));

endmodule

bind gshare_predictor gshare_checker #(.IDX_W(IDX_W), .HIST_W(HIST_W)) i_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .upd_valid_i(upd_valid_i),
  .upd_idx_i  (upd_idx_i),
  .upd_taken_i(upd_taken_i),
  .lkp_idx_o  (lkp_idx_o),
  .lkp_taken_o(lkp_taken_o),
  .hist_q     (hist_q),
  .ctr_q      (ctr_q)
);

// File: tb/test_gshare_predictor.sv
`timescale 1ns/1ps
module test_gshare_predictor;

  localparam int PC_W   = 12;
  localparam int IDX_W  = 4;
  localparam int HIST_W = 3;
  localparam int PC_LSB = 2;
  localparam int DEPTH  = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [PC_W-1:0]  lkp_pc = '0;
  logic             lkp_taken;
  logic [IDX_W-1:0] lkp_idx;
  logic             upd_valid = 1'b0;
  logic [IDX_W-1:0] upd_idx = '0;
  logic             upd_taken = 1'b0;

  int tests = 0;
  int fails = 0;
  int mcnt [DEPTH];
  int mhist = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  gshare_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .PC_LSB(PC_LSB)) i_gshare_predictor (
    .clk_i(clk), .rst_ni(rst_n), .lkp_pc_i(lkp_pc), .lkp_taken_o(lkp_taken),
    .lkp_idx_o(lkp_idx), .upd_valid_i(upd_valid), .upd_idx_i(upd_idx), .upd_taken_i(upd_taken)
  );

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [PC_W-1:0] pc_for(int e, int junk);
    int bits;
    bits = (e ^ mhist) & (DEPTH - 1);
    return PC_W'((junk << (PC_LSB + IDX_W)) | (bits << PC_LSB) | (junk & 3));
  endfunction

  function automatic void step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endfunction

  // aim a lookup at every entry; R2 for direction, R5 for index
  task automatic sweep();
    for (int e = 0; e < DEPTH; e++) begin
      lkp_pc = pc_for(e, e * 5 + 1);
      #1;
      check("R5 index", int'(lkp_idx), e);
      check("R2 prediction", int'(lkp_taken), (mcnt[e] >= 2) ? 1 : 0);
    end
  endtask

  task automatic update(bit v, int idx, bit t, int look);
    @(negedge clk);
    upd_valid = v;
    upd_idx   = IDX_W'(idx);
    upd_taken = t;
    lkp_pc    = pc_for(look, 3);
    #1;
    // R8: the lookup in the update cycle sees the pre-update counter
    check("R8 same-cycle lookup", int'(lkp_taken), (mcnt[look] >= 2) ? 1 : 0);
    @(posedge clk);
    #1;
    if (v) begin
      if (t) mcnt[idx] = (mcnt[idx] == 3) ? 3 : mcnt[idx] + 1;
      else   mcnt[idx] = (mcnt[idx] == 0) ? 0 : mcnt[idx] - 1;
      mhist = ((mhist << 1) | int'(t)) & ((1 << HIST_W) - 1);
    end
    upd_valid = 1'b0;
    sweep();
  endtask

  task automatic model_reset();
    for (int e = 0; e < DEPTH; e++) mcnt[e] = 1;
    mhist = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    model_reset();
    #2;
    // R1: every PC during reset
    for (int p = 0; p < (1 << PC_W); p++) begin
      lkp_pc = PC_W'(p);
      #0.1;
      check("R1 reset index", int'(lkp_idx), (p >> PC_LSB) & (DEPTH - 1));
      check("R1 reset direction", int'(lkp_taken), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    sweep();

    // R3 then R4 on entry 5, with the lookup aimed elsewhere (R6)
    begin
      int up_exp [4] = '{1, 1, 1, 1};
      int dn_exp [4] = '{1, 0, 0, 0};
      for (int k = 0; k < 4; k++) begin
        update(1'b1, 5, 1'b1, 9);
        lkp_pc = pc_for(5, 0); #1;
        check("R3 saturate up", int'(lkp_taken), up_exp[k]);
      end
      for (int k = 0; k < 4; k++) begin
        update(1'b1, 5, 1'b0, 2);
        lkp_pc = pc_for(5, 0); #1;
        check("R4 saturate down", int'(lkp_taken), dn_exp[k]);
      end
      update(1'b1, 5, 1'b1, 0);
      lkp_pc = pc_for(5, 0); #1;
      check("R4 floor then one taken", int'(lkp_taken), 0);
      update(1'b1, 5, 1'b1, 0);
      lkp_pc = pc_for(5, 0); #1;
      check("R3 weak taken reached", int'(lkp_taken), 1);
    end

    // R7: idle cycles with active-looking data
    for (int k = 0; k < 6; k++) update(1'b0, k * 3 % DEPTH, 1'b1, k);

    // mixed pseudo-random traffic
    for (int k = 0; k < 400; k++) begin
      step_lfsr();
      update(lfsr[1:0] != 2'b00, int'(lfsr[7:4]), lfsr[9], int'(lfsr[13:10]));
    end

    // R1: asynchronous reset in mid-run
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    model_reset();
    for (int e = 0; e < DEPTH; e++) begin
      lkp_pc = PC_W'(e << PC_LSB);
      #0.1;
      check("R1 re-reset index", int'(lkp_idx), e);
      check("R1 re-reset direction", int'(lkp_taken), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    update(1'b1, 0, 1'b1, 0);
    finish_run();
  end

endmodule